// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block collects 32 interrupt inputs and merges them into one interrupt line toward a processor. Each input has its own trigger type, built from two configuration bits. The mode bit picks edge or level detection. The polarity bit picks rising or high when set, and falling or low when clear. A detected event sets a per-source pending bit. That bit stays set until software writes a one to it. A per-source enable bit decides whether a pending source reaches the output.

The merged output has its own mode and polarity bits. In level mode the line is active while any enabled source is pending. In edge mode it gives a single-cycle pulse each time the first enabled pending source appears. A force register lets software make any source pend without toggling its input. Software reaches the block through a plain word-wide register port with a byte offset. Writes take effect on the clock edge. Reads are combinational.

Each input passes through a two-flop synchronizer before detection. When software changes a source's trigger type, it then writes a one to that source's pending bit. This removes any event latched during the change.

Top module: `trig_irq_agg`

## Requirements
- R1: After reset, all readable registers (enable 0x00, status 0x04, source mode 0x08, source polarity 0x0C, output mode 0x10, output polarity 0x14, force 0x18) read 0, and `irq_out` is 1, which is the inactive level of an active-low line. With all inputs held high, status stays 0.
- R2: A source with mode bit 1 is an edge source. With polarity 1 it latches on a rising edge and with polarity 0 on a falling edge. The opposite edge latches nothing. The status bit becomes visible on the third rising clock edge after the input changes.
- R3: A source with mode bit 0 is a level source. It latches while its input is at the active level: high for polarity 1, low for polarity 0. A clear written while the level is still active leaves the bit set.
- R4: Writing a 1 to a bit of status (0x04) clears that pending bit. A 0 leaves the bit unchanged. All ones clears every pending bit whose source is not firing. If a set and a clear hit the same bit in one cycle, the set wins.
- R5: Writing a 1 to a bit of force (0x18) sets the matching status bit on that clock edge. Force always reads 0.
- R6: Only sources whose enable bit (0x00) is 1 affect the output. A pending source with enable 0 leaves `irq_out` inactive.
- R7: With output mode (0x10, bit 0) at 0, `irq_out` equals the output polarity bit (0x14, bit 0) while any enabled source is pending. Otherwise it equals the inverse of that bit.
- R8: With output mode at 1, `irq_out` is at its active level for exactly one cycle when the set of enabled pending sources goes from empty to non-empty. It is inactive at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw interrupt inputs, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 1 | Merged interrupt line |

## Verification
Each result has a fixed due cycle. A register write is visible on the edge that samples it, so the bench drives each write at a falling edge and reads at the next falling edge. An input change takes three rising edges to reach status: two synchronizer stages, then the latch. The bench samples between the second and third edges to check that status is still clear, and after the third to check that it is set. Everywhere else it waits four cycles before reading. An output-edge pulse is checked in the half cycle after the force write, and again one cycle later to confirm it has ended.

// File: rtl/trig_irq_agg.sv
module trig_irq_agg #(
  parameter int NSRC = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_out
);
  localparam logic [AW-1:0] OFF_EN    = AW'(8'h00);
  localparam logic [AW-1:0] OFF_STAT  = AW'(8'h04);
  localparam logic [AW-1:0] OFF_SMODE = AW'(8'h08);
  localparam logic [AW-1:0] OFF_SPOL  = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_OMODE = AW'(8'h10);
  localparam logic [AW-1:0] OFF_OPOL  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_FORCE = AW'(8'h18);
  localparam logic [NSRC-1:0] ALL1 = {NSRC{1'b1}};

  logic [NSRC-1:0] sync1, sync2, prev;
  logic [NSRC-1:0] en_r, smode_r, spol_r, stat_r;
  logic            omode_r, opol_r, pend_q;

  wire sel_en    = wr_en && (addr == OFF_EN);
  wire sel_stat  = wr_en && (addr == OFF_STAT);
  wire sel_smode = wr_en && (addr == OFF_SMODE);
  wire sel_spol  = wr_en && (addr == OFF_SPOL);
  wire sel_omode = wr_en && (addr == OFF_OMODE);
  wire sel_opol  = wr_en && (addr == OFF_OPOL);
  wire sel_force = wr_en && (addr == OFF_FORCE);

  // Synchronizers idle high so level-low defaults stay quiet after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= ALL1;
      sync2 <= ALL1;
      prev  <= ALL1;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  wire [NSRC-1:0] rise     = sync2 & ~prev;
  wire [NSRC-1:0] fall     = ~sync2 & prev;
  wire [NSRC-1:0] edge_hit = smode_r & ((spol_r & rise) | (~spol_r & fall));
  wire [NSRC-1:0] lvl_hit  = ~smode_r & ~(sync2 ^ spol_r);
  wire [NSRC-1:0] frc_vec  = sel_force ? wdata : '0;
  wire [NSRC-1:0] clr_vec  = sel_stat ? wdata : '0;
  wire [NSRC-1:0] set_vec  = edge_hit | lvl_hit | frc_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r    <= '0;
      smode_r <= '0;
      spol_r  <= '0;
      stat_r  <= '0;
      omode_r <= 1'b0;
      opol_r  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (sel_en)    en_r    <= wdata;
      if (sel_smode) smode_r <= wdata;
      if (sel_spol)  spol_r  <= wdata;
      if (sel_omode) omode_r <= wdata[0];
      if (sel_opol)  opol_r  <= wdata[0];
      stat_r <= (stat_r & ~clr_vec) | set_vec;
      pend_q <= |(stat_r & en_r);
    end
  end

  wire pend    = |(stat_r & en_r);
  wire pulse   = pend & ~pend_q;
  wire irq_raw = omode_r ? pulse : pend;
  assign irq_out = ~(irq_raw ^ opol_r);

  always_comb begin
    case (addr)
      OFF_EN:    rdata = en_r;
      OFF_STAT:  rdata = stat_r;
      OFF_SMODE: rdata = smode_r;
      OFF_SPOL:  rdata = spol_r;
      OFF_OMODE: rdata = NSRC'(omode_r);
      OFF_OPOL:  rdata = NSRC'(opol_r);
      default:   rdata = '0;
    endcase
  end

  a_r5_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sel_force |=> ((stat_r & $past(wdata)) == $past(wdata)));

  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stat && wdata == ALL1 && set_vec == '0) |=> (stat_r == '0));

  a_r3_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_hit) |=> ((stat_r & $past(lvl_hit)) == $past(lvl_hit)));

  a_r7_level_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!omode_r && (stat_r & en_r) != '0) |-> (irq_out == opol_r));

  a_r8_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    (omode_r && opol_r && irq_out) |=> (!omode_r || !opol_r || !irq_out));

endmodule

// File: tb/trig_irq_agg_test.sv
module trig_irq_agg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_EN = 5'h00, A_ST = 5'h04, A_SM = 5'h08, A_SP = 5'h0C,
                         A_OM = 5'h10, A_OP = 5'h14, A_FR = 5'h18;
  // {mode, polarity, start level, end level, expected status}
  localparam logic [4:0] VEC [0:7] = '{
    5'b11011, 5'b11100, 5'b10101, 5'b10010,
    5'b01011, 5'b01000, 5'b00101, 5'b00110 };

  logic clk = 0, rst_n = 0, wr_en = 0, irq_out;
  logic [31:0] src_in = '1, wdata = '0, rdata, v;
  logic [4:0] addr = '0;
  int checks = 0, errors = 0;

  trig_irq_agg uut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(3);
    // R1 reset state
    for (int a = 0; a <= 24; a += 4) begin
      rd(5'(a), v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq_out", {31'b0, irq_out}, 1);

    // R2/R3 trigger table on source 0
    for (int i = 0; i < 8; i++) begin
      wr(A_SM, {31'b0, VEC[i][4]});
      wr(A_SP, {31'b0, VEC[i][3]});
      src_in[0] = VEC[i][2];
      idle(4);
      wr(A_ST, 32'h1);
      src_in[0] = VEC[i][1];
      idle(4);
      rd(A_ST, v);
      chk(VEC[i][4] ? "R2 edge trigger" : "R3 level trigger", {31'b0, v[0]}, {31'b0, VEC[i][0]});
    end

    // R2 latency: rising edge visible on third clock edge
    wr(A_SM, 32'h1); wr(A_SP, 32'h1); src_in[0] = 0; idle(4); wr(A_ST, 32'h1);
    src_in[0] = 1; idle(2);
    rd(A_ST, v); chk("R2 not yet after two edges", {31'b0, v[0]}, 0);
    idle(1);
    rd(A_ST, v); chk("R2 set after third edge", {31'b0, v[0]}, 1);

    // R3 clear while level active does not stick
    wr(A_SM, 32'h0); wr(A_SP, 32'h1); idle(4);
    wr(A_ST, 32'h1);
    rd(A_ST, v); chk("R3 clear during active level", {31'b0, v[0]}, 1);

    // back to quiet: level low with input high
    wr(A_SP, 32'h0); idle(4); wr(A_ST, '1);
    rd(A_ST, v); chk("R4 clear all", v, 0);

    // R5 force and readback
    wr(A_FR, 32'h8000_0008);
    rd(A_ST, v); chk("R5 force sets status", v, 32'h8000_0008);
    rd(A_FR, v); chk("R5 force reads zero", v, 0);
    // R4 write of zero leaves status
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk("R4 zero write keeps status", v, 32'h8000_0008);
    wr(A_ST, 32'h0000_0008);
    rd(A_ST, v); chk("R4 single bit clear", v, 32'h8000_0000);
    wr(A_FR, 32'hF0F0_0000); wr(A_ST, '1);
    rd(A_ST, v); chk("R4 clear all after force", v, 0);

    // R6 enable mask, R7 output level polarity
    wr(A_FR, 32'h20);
    chk("R6 masked source quiet", {31'b0, irq_out}, 1);
    wr(A_EN, 32'h1);
    chk("R6 other enable quiet", {31'b0, irq_out}, 1);
    wr(A_EN, 32'h20);
    chk("R7 active-low asserted", {31'b0, irq_out}, 0);
    wr(A_OP, 32'h1);
    chk("R7 active-high asserted", {31'b0, irq_out}, 1);
    wr(A_ST, 32'h20);
    chk("R7 active-high idle", {31'b0, irq_out}, 0);

    // R8 output pulse mode
    wr(A_OM, 32'h1);
    chk("R8 idle before pulse", {31'b0, irq_out}, 0);
    wr(A_FR, 32'h20);
    chk("R8 pulse asserted", {31'b0, irq_out}, 1);
    idle(1);
    chk("R8 pulse lasts one cycle", {31'b0, irq_out}, 0);
    wr(A_FR, 32'h20);
    chk("R8 no pulse while still pending", {31'b0, irq_out}, 0);
    wr(A_ST, '1); idle(1);
    wr(A_FR, 32'h20);
    chk("R8 pulse after re-arm", {31'b0, irq_out}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule